// File: doc/BRIEF.md
# Stream operator firing controller

This block is the control half of a stateful streaming operator. It has two input streams, x and y, and one output stream, o. Each stream has a valid flag, a backpressure flag and an end-of-stream marker. The marker travels as one extra bit next to the data word. A word moves on a rising clock edge when its valid flag is high and its backpressure flag is low.

In every cycle the controller checks the input signature of its current state. Each input that the state requires must be valid and must carry the end-of-stream value the state expects. If the state emits, the output must not be backpressured. When all of this holds the controller fires in the same cycle. It lowers backpressure only on the inputs the state consumes, raises valid only on the output the state emits, and moves to the next state on the clock edge. In every other cycle it stalls: all inputs stay backpressured, the output stays invalid and the state holds.

A separate datapath module, outside this block, receives the current state code and the fire strobe, and it returns boolean flags that steer branching. The controller reacts combinationally to its stream flags, so it acts as a slave on its streams. Every one of its streams must therefore be connected to a queue and never directly to another operator.

Top module: `sfsm_fire_ctrl`

## Requirements
- R1: A synchronous reset puts the controller in state ONE, with the state code equal to 0 on `dp_state`. After reset, with no input valid, `o_valid` and `dp_fire` are 0 and `x_bp` and `y_bp` are 1. A reset applied while the controller is in state TWO also returns it to state ONE.
- R2: In any cycle that does not fire, `x_bp` and `y_bp` are 1, `o_valid` and `dp_fire` are 0, and the state code keeps its value across the next edge.
- R3: In state ONE the controller fires when x is valid with `x_eos`=0, y is valid with `y_eos`=1 and `o_bp`=0. In that cycle `x_bp`=0, `y_bp`=0, `o_valid`=1, `o_eos`=0 and `dp_fire`=1.
- R4: In state ONE the controller stalls if y carries a data token (`y_eos`=0) or if x carries an end-of-stream token (`x_eos`=1).
- R5: No output token is offered while `o_bp` is high: in state ONE, `o_bp`=1 stalls the controller even when both inputs match.
- R6: A firing in state ONE moves the state code to 1 (state TWO) on the next edge.
- R7: In state TWO the controller fires when x is valid with `x_eos`=0, whatever y and `o_bp` do. While in state TWO, `y_bp` stays 1 and `o_valid` stays 0.
- R8: A firing in state TWO moves the controller to state ONE when bit `BRANCH_BIT` of `dp_flag` is 0 and keeps it in state TWO when that bit is 1.
- R9: `dp_state` always presents the current state code, zero-extended to `STATE_W` bits: ONE=0, TWO=1.
- R10: An input's backpressure is low only in a cycle where `dp_fire` is 1, so no input token is consumed without a firing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| x_valid | input | 1 | Input x offers a token |
| x_eos | input | 1 | Input x token is an end-of-stream marker |
| x_bp | output | 1 | Backpressure on input x (1 = not accepted) |
| y_valid | input | 1 | Input y offers a token |
| y_eos | input | 1 | Input y token is an end-of-stream marker |
| y_bp | output | 1 | Backpressure on input y |
| o_valid | output | 1 | Output o offers a token |
| o_eos | output | 1 | Output token end-of-stream marker |
| o_bp | input | 1 | Backpressure from the queue on output o |
| dp_flag | input | FLAG_W | Branch flags from the datapath |
| dp_state | output | STATE_W | Current state code sent to the datapath |
| dp_fire | output | 1 | Fire strobe sent to the datapath |

## Verification
A firing in state ONE does three things in one cycle: it consumes x, it consumes y and it emits on o. Any one of these three conditions can hold alone without firing, while backpressure must still stay high on both inputs. The vector table sets up each partial match: a missing y, a wrong end-of-stream value on either input, and a match held back by output backpressure. Each row is judged on all three handshakes and on the fire strobe, and the state code is checked in the following row. A random phase then compares every cycle against a separate state model, which confirms that any lowered backpressure or raised output valid falls only in a firing cycle.

// File: rtl/sfsm_pkg.sv
package sfsm_pkg;

   localparam int NUM_IN = 2;
   localparam int IN_X   = 0;
   localparam int IN_Y   = 1;

   typedef enum logic [1:0] {
      ST_ONE = 2'd0,
      ST_TWO = 2'd1
   } state_t;

   // per-state firing signature
   typedef struct packed {
      logic [NUM_IN-1:0] need;      // input must be present
      logic [NUM_IN-1:0] want_eos;  // expected end-of-stream bit
      logic              emit;      // state produces an output token
   } sig_t;

   function automatic sig_t state_signature(state_t s);
      sig_t r;
      r = '0;
      case (s)
         ST_ONE: begin
            r.need           = '1;
            r.want_eos[IN_Y] = 1'b1;
            r.emit           = 1'b1;
         end
         ST_TWO: begin
            r.need[IN_X]     = 1'b1;
         end
         default: r = '0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/sfsm_in_match.sv
module sfsm_in_match (
   input  logic need,
   input  logic want_eos,
   input  logic valid,
   input  logic eos,
   output logic ok
);
   assign ok = !need || (valid && (eos == want_eos));
endmodule

// File: rtl/sfsm_state_seq.sv
module sfsm_state_seq
   import sfsm_pkg::*;
#(
   parameter int FLAG_W     = 1,
   parameter int BRANCH_BIT = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fire,
   input  logic [FLAG_W-1:0] flags,
   output state_t            state
);
   state_t nxt;

   always_comb begin
      case (state)
         ST_ONE:  nxt = ST_TWO;
         ST_TWO:  nxt = flags[BRANCH_BIT] ? ST_TWO : ST_ONE;
         default: nxt = ST_ONE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)       state <= ST_ONE;
      else if (fire) state <= nxt;
   end
endmodule

// File: rtl/sfsm_fire_ctrl.sv
module sfsm_fire_ctrl
   import sfsm_pkg::*;
#(
   parameter int STATE_W    = 2,
   parameter int FLAG_W     = 1,
   parameter int BRANCH_BIT = 0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               x_valid,
   input  logic               x_eos,
   output logic               x_bp,
   input  logic               y_valid,
   input  logic               y_eos,
   output logic               y_bp,
   output logic               o_valid,
   output logic               o_eos,
   input  logic               o_bp,
   input  logic [FLAG_W-1:0]  dp_flag,
   output logic [STATE_W-1:0] dp_state,
   output logic               dp_fire
);
   localparam int CODE_W = $bits(state_t);

   generate
      if (STATE_W < CODE_W) begin : g_bad_state_w
         $error("STATE_W too narrow for the state code");
      end
      if (BRANCH_BIT >= FLAG_W) begin : g_bad_branch
         $error("BRANCH_BIT outside dp_flag");
      end
   endgenerate

   state_t            cur;
   sig_t              sg;
   logic [NUM_IN-1:0] vin, ein, ok, bpv;
   logic              fire;

   assign vin = {y_valid, x_valid};
   assign ein = {y_eos, x_eos};
   assign sg  = state_signature(cur);

   generate
      for (genvar i = 0; i < NUM_IN; i++) begin : g_in
         sfsm_in_match u_match (
            .need     (sg.need[i]),
            .want_eos (sg.want_eos[i]),
            .valid    (vin[i]),
            .eos      (ein[i]),
            .ok       (ok[i])
         );
         assign bpv[i] = !(fire && sg.need[i]);
      end
   endgenerate

   assign fire = (&ok) && (!sg.emit || !o_bp);

   sfsm_state_seq #(
      .FLAG_W     (FLAG_W),
      .BRANCH_BIT (BRANCH_BIT)
   ) u_seq (
      .clk   (clk),
      .rst   (rst),
      .fire  (fire),
      .flags (dp_flag),
      .state (cur)
   );

   assign x_bp     = bpv[IN_X];
   assign y_bp     = bpv[IN_Y];
   assign o_valid  = fire && sg.emit;
   assign o_eos    = 1'b0;
   assign dp_fire  = fire;
   assign dp_state = STATE_W'(cur);
endmodule

// File: rtl/sfsm_fire_ctrl_chk.sv
module sfsm_fire_ctrl_chk #(
   parameter int STATE_W    = 2,
   parameter int FLAG_W     = 1,
   parameter int BRANCH_BIT = 0
) (
   input logic               clk,
   input logic               rst,
   input logic               x_valid,
   input logic               x_eos,
   input logic               x_bp,
   input logic               y_valid,
   input logic               y_eos,
   input logic               y_bp,
   input logic               o_valid,
   input logic               o_eos,
   input logic               o_bp,
   input logic [FLAG_W-1:0]  dp_flag,
   input logic [STATE_W-1:0] dp_state,
   input logic               dp_fire
);
   localparam logic [STATE_W-1:0] C_ONE = STATE_W'(0);
   localparam logic [STATE_W-1:0] C_TWO = STATE_W'(1);

   p_consume_needs_fire_r10: assert property (@(posedge clk) disable iff (rst)
      (!x_bp || !y_bp) |-> dp_fire);

   p_no_emit_under_bp_r5: assert property (@(posedge clk) disable iff (rst)
      o_valid |-> !o_bp);

   p_stall_holds_r2: assert property (@(posedge clk) disable iff (rst)
      !dp_fire |=> $stable(dp_state));

   p_one_fire_r3: assert property (@(posedge clk) disable iff (rst)
      (dp_fire && dp_state == C_ONE) |-> (o_valid && !o_eos && !x_bp && !y_bp
                                          && x_valid && y_valid && y_eos && !x_eos));

   p_one_to_two_r6: assert property (@(posedge clk) disable iff (rst)
      (dp_fire && dp_state == C_ONE) |=> (dp_state == C_TWO));

   p_two_silent_r7: assert property (@(posedge clk) disable iff (rst)
      (dp_state == C_TWO) |-> (!o_valid && y_bp));

   p_two_stay_r8: assert property (@(posedge clk) disable iff (rst)
      (dp_fire && dp_state == C_TWO && dp_flag[BRANCH_BIT]) |=> (dp_state == C_TWO));

   p_two_leave_r8: assert property (@(posedge clk) disable iff (rst)
      (dp_fire && dp_state == C_TWO && !dp_flag[BRANCH_BIT]) |=> (dp_state == C_ONE));

   p_legal_code_r9: assert property (@(posedge clk) disable iff (rst)
      (dp_state == C_ONE) || (dp_state == C_TWO));
endmodule

bind sfsm_fire_ctrl sfsm_fire_ctrl_chk #(
   .STATE_W    (STATE_W),
   .FLAG_W     (FLAG_W),
   .BRANCH_BIT (BRANCH_BIT)
) u_chk (.*);

// File: tb/sfsm_fire_ctrl_tb_top.sv
module sfsm_fire_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       x_valid = 1'b0, x_eos = 1'b0, y_valid = 1'b0, y_eos = 1'b0;
   logic       o_bp = 1'b0;
   logic [0:0] dp_flag = 1'b0;
   logic       x_bp, y_bp, o_valid, o_eos, dp_fire;
   logic [1:0] dp_state;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   sfsm_fire_ctrl dut_i (
      .clk(clk), .rst(rst),
      .x_valid(x_valid), .x_eos(x_eos), .x_bp(x_bp),
      .y_valid(y_valid), .y_eos(y_eos), .y_bp(y_bp),
      .o_valid(o_valid), .o_eos(o_eos), .o_bp(o_bp),
      .dp_flag(dp_flag), .dp_state(dp_state), .dp_fire(dp_fire)
   );

   // {state, xv, xe, yv, ye, obp, flag, xbp, ybp, ov, fire}
   localparam int NV = 13;
   localparam logic [10:0] VEC [NV] = '{
      11'b0_000000_1100,
      11'b0_100000_1100,
      11'b0_101000_1100,
      11'b0_111100_1100,
      11'b0_101110_1100,
      11'b0_101100_0011,
      11'b1_001100_1100,
      11'b1_110001_1100,
      11'b1_101111_0101,
      11'b1_100000_0101,
      11'b0_101100_0011,
      11'b1_100000_0101,
      11'b0_000000_1100
   };

   function automatic string row_tag(int i);
      case (i)
         0, 1, 6, 12: return "R2";
         2, 3:        return "R4";
         4:           return "R5";
         5:           return "R3";
         7, 8:        return "R7";
         10:          return "R6";
         default:     return "R8";
      endcase
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic drive(logic xv, logic xe, logic yv, logic ye, logic ob, logic fl);
      x_valid = xv; x_eos = xe; y_valid = yv; y_eos = ye; o_bp = ob; dp_flag = fl;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int mstate;
      logic efire, exbp, eybp, eov;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #5;
      // R1 reset state
      chk("R1", "dp_state", dp_state, 0);
      chk("R1", "o_valid", o_valid, 0);
      chk("R1", "dp_fire", dp_fire, 0);
      chk("R1", "x_bp", x_bp, 1);
      chk("R1", "y_bp", y_bp, 1);

      for (int i = 0; i < NV; i++) begin
         logic [10:0] v;
         v = VEC[i];
         @(negedge clk);
         drive(v[9], v[8], v[7], v[6], v[5], v[4]);
         #5;
         chk("R9", $sformatf("row%0d dp_state", i), dp_state, v[10]);
         chk(row_tag(i), $sformatf("row%0d x_bp", i), x_bp, v[3]);
         chk(row_tag(i), $sformatf("row%0d y_bp", i), y_bp, v[2]);
         chk(row_tag(i), $sformatf("row%0d o_valid", i), o_valid, v[1]);
         chk(row_tag(i), $sformatf("row%0d dp_fire", i), dp_fire, v[0]);
         if (v[1]) chk("R3", $sformatf("row%0d o_eos", i), o_eos, 0);
      end

      // R1 reset while in state TWO
      @(negedge clk);
      drive(1, 0, 1, 1, 0, 0);
      @(negedge clk);
      drive(0, 0, 0, 0, 0, 0);
      #5;
      chk("R6", "entered TWO before reset", dp_state, 1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #5;
      chk("R1", "dp_state after reset in TWO", dp_state, 0);

      // random phase against an independent model
      mstate = 0;
      for (int c = 0; c < 400; c++) begin
         logic [5:0] r;
         @(negedge clk);
         r = 6'($urandom);
         if (c % 3 == 0) r[4:1] = 4'b1011; // bias towards matching ONE signature
         drive(r[0] | r[4], r[1] & ~r[4], r[2] | r[4], r[3] | r[4], r[5], 1'($urandom));
         #5;
         if (mstate == 0) begin
            efire = x_valid && !x_eos && y_valid && y_eos && !o_bp;
            exbp = !efire; eybp = !efire; eov = efire;
         end else begin
            efire = x_valid && !x_eos;
            exbp = !efire; eybp = 1'b1; eov = 1'b0;
         end
         chk("R9", "rand dp_state", dp_state, mstate);
         chk("R10", "rand dp_fire", dp_fire, efire);
         chk("R10", "rand x_bp", x_bp, exbp);
         chk("R7", "rand y_bp", y_bp, eybp);
         chk("R5", "rand o_valid", o_valid, eov);
         if (efire) mstate = (mstate == 0) ? 1 : (dp_flag[0] ? 1 : 0);
      end

      finish_run();
   end
endmodule